// File: doc/BRIEF.md
# Remote-Bus Reservation Bridge

This block sits between a local bus master and a remote bus and makes load-reserve / store-conditional pairs work across that boundary. It holds one reservation: a valid flag and the 30-bit word address that was reserved. A reserved load aimed at the remote region arms the reservation. A write by another remote master to that word disarms it.

A store-conditional on the local side either succeeds or fails. On success it is acknowledged and forwarded to the remote bus as a write. On failure it is answered with a kill indication and is not carried out remotely. Because the pass/fail decision is made before the forwarded request is issued, a failed store-conditional never starts on the remote bus, so it never has to be aborted there.

Every local transfer is sampled on the clock edge where its start strobe is high. Its response appears as a one-cycle pulse on the following cycle, from registered outputs.

Top module: `rsv_bridge`

## Requirements
- R1: A reserved load (strobe=1, we=0, rsv=1) to an address inside the remote region arms the reservation and records its word address. The remote region is the set of addresses with `(addr & REM_MASK) == REM_BASE`; by default this is the upper two address bits equal to 01. The load itself is acknowledged and forwarded as a remote read.
- R2: A reserved load outside the remote region leaves both the flag and the recorded address unchanged.
- R3: A reserved load to a new remote address replaces the recorded address and re-arms the flag.
- R4: A snooped remote write (valid=1, we=1) to the recorded address clears the flag. A snooped write to any other address has no effect on the flag. A snooped read (we=0) to any address has no effect on the flag.
- R5: A store-conditional (strobe=1, we=1, rsv=1) succeeds when the flag is set and its address equals the recorded one. On success, the next cycle pulses the acknowledge and a remote request with we=1 and the same address.
- R6: Any store-conditional that does not succeed fails. On failure, the next cycle pulses kill, with no acknowledge and no remote request.
- R7: After any store-conditional, whether it succeeds or fails, the flag is clear.
- R8: Reset clears the flag and all outputs. A store-conditional issued before any reserved load therefore fails.
- R9: If a snooped write hits the recorded address in the same cycle as a store-conditional to it, the store-conditional fails.
- R10: If a snooped write hits the recorded address in the same cycle as a reserved load to that address, the flag ends set.
- R11: An ordinary read or write is acknowledged on the next cycle. It is forwarded with the same direction and address only if it falls inside the remote region.
- R12: Acknowledge and kill are never high together. Each is a single-cycle pulse that follows a sampled transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_ts_i | input | 1 | Local transfer-start strobe |
| loc_we_i | input | 1 | Local direction, 1 = write |
| loc_rsv_i | input | 1 | Local reservation attribute |
| loc_addr_i | input | AW | Local word address |
| loc_ack_o | output | 1 | Normal acknowledge pulse |
| loc_kill_o | output | 1 | Kill-reservation pulse (failed store-conditional) |
| snp_vld_i | input | 1 | Remote cycle by another master is present |
| snp_we_i | input | 1 | Direction of the snooped remote cycle |
| snp_addr_i | input | AW | Word address of the snooped remote cycle |
| rem_req_o | output | 1 | Forwarded remote request pulse |
| rem_we_o | output | 1 | Direction of the forwarded request |
| rem_addr_o | output | AW | Word address of the forwarded request |

## Verification
A snooped remote write and a local transfer can land on the reserved word in the same cycle. The two cases that matter are a store-conditional paired with the snoop, and a reserved load paired with the snoop. The bench drives both inputs on the same clock edge. It judges the store-conditional case by a kill pulse with no remote request. It judges the load case by a later store-conditional that must succeed, which shows that the load left the flag armed.

// File: rtl/rsv_bridge_pkg.sv
package rsv_bridge_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_READ,
    OP_LOAD_RSV,
    OP_WRITE,
    OP_STORE_COND
  } op_e;
endpackage

// File: rtl/rsv_op_decode.sv
module rsv_op_decode
  import rsv_bridge_pkg::*;
(
  input  logic ts_i,
  input  logic we_i,
  input  logic rsv_i,
  output op_e  op_o
);
  always_comb begin
    if (!ts_i)                op_o = OP_IDLE;
    else if (we_i && rsv_i)   op_o = OP_STORE_COND;
    else if (we_i)            op_o = OP_WRITE;
    else if (rsv_i)           op_o = OP_LOAD_RSV;
    else                      op_o = OP_READ;
  end
endmodule

// File: rtl/rsv_region_dec.sv
module rsv_region_dec #(
  parameter int unsigned    AW       = 30,
  parameter logic [AW-1:0]  REM_BASE = '0,
  parameter logic [AW-1:0]  REM_MASK = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  assign hit_o = ((addr_i & REM_MASK) == REM_BASE);
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
  import rsv_bridge_pkg::*;
#(
  parameter int unsigned AW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic          in_region_i,
  input  logic [AW-1:0] addr_i,
  input  logic          snp_vld_i,
  input  logic          snp_we_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          sc_pass_o
);
  logic          flag_q;
  logic [AW-1:0] raddr_q;
  logic          snoop_hit;
  logic          arm;

  assign snoop_hit = snp_vld_i && snp_we_i && flag_q && (snp_addr_i == raddr_q);
  assign arm       = (op_i == OP_LOAD_RSV) && in_region_i;
  // snoop hit in the same cycle beats the store-conditional
  assign sc_pass_o = (op_i == OP_STORE_COND) && flag_q &&
                     (addr_i == raddr_q) && !snoop_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      raddr_q <= '0;
    end else if (arm) begin
      // reserved load wins over a same-cycle snoop
      flag_q  <= 1'b1;
      raddr_q <= addr_i;
    end else if (op_i == OP_STORE_COND || snoop_hit) begin
      flag_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/rsv_resp.sv
module rsv_resp
  import rsv_bridge_pkg::*;
#(
  parameter int unsigned AW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic          in_region_i,
  input  logic          sc_pass_i,
  input  logic [AW-1:0] addr_i,
  output logic          ack_o,
  output logic          kill_o,
  output logic          rem_req_o,
  output logic          rem_we_o,
  output logic [AW-1:0] rem_addr_o
);
  logic sc_fail, is_wr, active;

  assign active  = (op_i != OP_IDLE);
  assign sc_fail = (op_i == OP_STORE_COND) && !sc_pass_i;
  assign is_wr   = (op_i == OP_WRITE) || (op_i == OP_STORE_COND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      kill_o     <= 1'b0;
      rem_req_o  <= 1'b0;
      rem_we_o   <= 1'b0;
      rem_addr_o <= '0;
    end else begin
      ack_o     <= active && !sc_fail;
      kill_o    <= sc_fail;
      // failed store-conditional is never started remotely
      rem_req_o <= active && in_region_i && !sc_fail;
      if (active) begin
        rem_we_o   <= is_wr;
        rem_addr_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/rsv_bridge.sv
module rsv_bridge
  import rsv_bridge_pkg::*;
#(
  parameter int unsigned   AW       = 30,
  parameter logic [AW-1:0] REM_BASE = AW'(30'h1000_0000),
  parameter logic [AW-1:0] REM_MASK = AW'(30'h3000_0000)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          loc_ts_i,
  input  logic          loc_we_i,
  input  logic          loc_rsv_i,
  input  logic [AW-1:0] loc_addr_i,
  output logic          loc_ack_o,
  output logic          loc_kill_o,
  input  logic          snp_vld_i,
  input  logic          snp_we_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          rem_req_o,
  output logic          rem_we_o,
  output logic [AW-1:0] rem_addr_o
);
  op_e  op;
  logic in_region;
  logic sc_pass;

  rsv_op_decode u_dec (
    .ts_i (loc_ts_i),
    .we_i (loc_we_i),
    .rsv_i(loc_rsv_i),
    .op_o (op)
  );

  rsv_region_dec #(.AW(AW), .REM_BASE(REM_BASE), .REM_MASK(REM_MASK)) u_region (
    .addr_i(loc_addr_i),
    .hit_o (in_region)
  );

  rsv_tracker #(.AW(AW)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .in_region_i(in_region),
    .addr_i     (loc_addr_i),
    .snp_vld_i  (snp_vld_i),
    .snp_we_i   (snp_we_i),
    .snp_addr_i (snp_addr_i),
    .sc_pass_o  (sc_pass)
  );

  rsv_resp #(.AW(AW)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .in_region_i(in_region),
    .sc_pass_i  (sc_pass),
    .addr_i     (loc_addr_i),
    .ack_o      (loc_ack_o),
    .kill_o     (loc_kill_o),
    .rem_req_o  (rem_req_o),
    .rem_we_o   (rem_we_o),
    .rem_addr_o (rem_addr_o)
  );
endmodule

// File: rtl/rsv_bridge_chk.sv
module rsv_bridge_chk #(
  parameter int unsigned   AW       = 30,
  parameter logic [AW-1:0] REM_BASE = '0,
  parameter logic [AW-1:0] REM_MASK = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          loc_ts_i,
  input logic          loc_we_i,
  input logic          loc_rsv_i,
  input logic          loc_ack_o,
  input logic          loc_kill_o,
  input logic          rem_req_o,
  input logic [AW-1:0] rem_addr_o
);
  // R12
  ack_kill_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(loc_ack_o && loc_kill_o));

  // R6
  kill_no_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_kill_o |-> !rem_req_o);

  // R6
  kill_from_sc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_kill_o |-> $past(loc_ts_i && loc_we_i && loc_rsv_i));

  // R12
  ack_follows_ts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_ack_o |-> $past(loc_ts_i));

  // R11
  fwd_in_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_req_o |-> ((rem_addr_o & REM_MASK) == REM_BASE));
endmodule

bind rsv_bridge rsv_bridge_chk #(.AW(AW), .REM_BASE(REM_BASE), .REM_MASK(REM_MASK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .loc_ts_i  (loc_ts_i),
  .loc_we_i  (loc_we_i),
  .loc_rsv_i (loc_rsv_i),
  .loc_ack_o (loc_ack_o),
  .loc_kill_o(loc_kill_o),
  .rem_req_o (rem_req_o),
  .rem_addr_o(rem_addr_o)
);

// File: tb/rsv_bridge_tb_top.sv
module rsv_bridge_tb_top;
  localparam int AW = 30;
  localparam logic [AW-1:0] A = 30'h1000_0010;
  localparam logic [AW-1:0] B = 30'h1000_0020;
  localparam logic [AW-1:0] L = 30'h0000_0040;

  typedef struct packed {
    logic          ts, we, rsv;
    logic [AW-1:0] a;
    logic          sv, swe;
    logic [AW-1:0] sa;
    logic          ack, kill, req;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1,1,1,A, 0,0,L, 0,1,0, 8},   // R8 sc before any load fails
    '{1,0,1,A, 0,0,L, 1,0,1, 1},   // R1
    '{1,1,1,A, 0,0,L, 1,0,1, 5},   // R5
    '{1,1,1,A, 0,0,L, 0,1,0, 7},   // R7 cleared after success
    '{1,0,1,A, 0,0,L, 1,0,1, 1},
    '{0,0,0,L, 1,1,B, 0,0,0, 4},   // R4 write elsewhere
    '{0,0,0,L, 1,0,A, 0,0,0, 4},   // R4 read same word
    '{1,1,1,A, 0,0,L, 1,0,1, 4},
    '{1,0,1,A, 0,0,L, 1,0,1, 1},
    '{0,0,0,L, 1,1,A, 0,0,0, 4},
    '{1,1,1,A, 0,0,L, 0,1,0, 4},   // R4 snoop hit cleared
    '{1,0,1,A, 0,0,L, 1,0,1, 1},
    '{1,0,1,L, 0,0,L, 1,0,0, 2},   // R2
    '{1,1,1,A, 0,0,L, 1,0,1, 2},
    '{1,0,1,A, 0,0,L, 1,0,1, 1},
    '{1,0,1,B, 0,0,L, 1,0,1, 3},
    '{1,1,1,A, 0,0,L, 0,1,0, 3},   // R3 replaced
    '{1,1,1,B, 0,0,L, 0,1,0, 7},   // R7 cleared after failure
    '{1,0,1,B, 0,0,L, 1,0,1, 1},
    '{1,1,1,B, 0,0,L, 1,0,1, 5},
    '{1,1,0,L, 0,0,L, 1,0,0, 11},  // R11
    '{1,0,0,B, 0,0,L, 1,0,1, 11},
    '{1,1,0,B, 0,0,L, 1,0,1, 11},
    '{1,0,1,A, 0,0,L, 1,0,1, 1},
    '{1,1,1,A, 1,1,A, 0,1,0, 9},   // R9
    '{1,0,1,A, 1,1,A, 1,0,1, 10},  // R10
    '{1,1,1,A, 0,0,L, 1,0,1, 10},
    '{0,0,0,L, 0,0,L, 0,0,0, 12}   // R12 pulses drop
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ts = 0, we = 0, rsv = 0, sv = 0, swe = 0;
  logic [AW-1:0] addr = '0, saddr = '0;
  logic          ack, kill, req, rwe;
  logic [AW-1:0] raddr;
  int            n_run = 0, n_fail = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  rsv_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .loc_ts_i(ts), .loc_we_i(we), .loc_rsv_i(rsv), .loc_addr_i(addr),
    .loc_ack_o(ack), .loc_kill_o(kill),
    .snp_vld_i(sv), .snp_we_i(swe), .snp_addr_i(saddr),
    .rem_req_o(req), .rem_we_o(rwe), .rem_addr_o(raddr)
  );

  task automatic check3(input int r, input logic ea, input logic ek, input logic er);
    n_run++;
    if ({ack, kill, req} !== {ea, ek, er}) begin
      n_fail++;
      $display("FAIL R%0d ack/kill/req=%b%b%b expected %b%b%b", r, ack, kill, req, ea, ek, er);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    ts = v.ts; we = v.we; rsv = v.rsv; addr = v.a;
    sv = v.sv; swe = v.swe; saddr = v.sa;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #12;
    check3(8, 0, 0, 0);  // R8 outputs low in reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check3(int'(VECS[i].rq), VECS[i].ack, VECS[i].kill, VECS[i].req);
      if (VECS[i].req) begin
        n_run++;  // R11 direction and address of forwarded request
        if (rwe !== VECS[i].we || raddr !== VECS[i].a) begin
          n_fail++;
          $display("FAIL R11 we/addr=%b/%h expected %b/%h", rwe, raddr, VECS[i].we, VECS[i].a);
        end
      end
    end
    // R8 reset mid-run drops a live reservation
    drive('{1,0,1,A, 0,0,L, 1,0,1, 8});
    @(negedge clk);
    ts = 0; rsv = 0; we = 0;
    rst_n = 1'b0;
    #1;
    check3(8, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive('{1,1,1,A, 0,0,L, 0,1,0, 8});
    check3(8, 0, 1, 0);
    @(negedge clk);
    ts = 0; we = 0; rsv = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule